// File: doc/BRIEF.md
# Wide-Immediate Move Decoder and Register Writer

This block accepts one 32-bit instruction word per valid strobe and recognises two register-load forms that each carry a 16-bit constant. The low-half form places its constant in bits 15:0 of the chosen register and clears bits 31:16. The top-half form places its constant in bits 31:16 and keeps bits 15:0 unchanged. An instruction word is at most 32 bits wide, so it cannot hold a full 32-bit constant. A full constant therefore takes two instructions: the low-half form first, then the top-half form.

The 16-bit constant is stored in four separate fields across the two halfwords of the word. The block gathers these fields back into one value, picks out the destination index, and performs a read-modify-write on an internal file of sixteen 32-bit registers. A combinational debug port reads any register. A word that matches neither form raises an undefined flag for one cycle. A word that names register 13 or 15 as its destination raises an unpredictable flag for one cycle. In both cases nothing is written.

Top module: `wideMoveUnit`

## Requirements
- R1: After reset every register reads 0 on the debug port, and both flags are low.
- R2: A low-half word writes {16'h0000, imm16} to the destination register. Word 0xF6430008 is a low-half move of 0x3808 to register 0.
- R3: A top-half word writes imm16 to bits 31:16 of the destination and leaves bits 15:0 unchanged. Word 0xF2C40002 is a top-half move of 0x4002 to register 0.
- R4: The word matches when bits 31:27 = 11110, bits 25:24 = 10, bits 22:20 = 100 and bit 15 = 0. Bit 23 selects the form (0 = low-half, 1 = top-half). The destination index is bits 11:8. imm16 = {bits 19:16, bit 26, bits 14:12, bits 7:0}.
- R5: Issuing 0xF6430008 and then 0xF2C40002 leaves register 0 holding 0x40023808.
- R6: A write takes effect on the clock edge that samples the strobe. A debug read in the strobe cycle returns the old value, and a read after that edge returns the new value.
- R7: A strobed word that does not match raises the undefined flag in the cycle after the strobe, for that one cycle only, and leaves every register unchanged.
- R8: A matching word whose destination is 13 or 15 raises the unpredictable flag in the cycle after the strobe, for that one cycle only, and writes nothing.
- R9: When the strobe is low, no register changes and both flags are low in the next cycle, whatever the word input holds.
- R10: The debug port returns the current contents of the register at any index it is given.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| instrValid | input | 1 | Strobe: instrWord is to be executed this cycle |
| instrWord | input | 32 | Instruction word, first halfword in bits 31:16 |
| dbgAddr | input | 4 | Debug read register index |
| dbgData | output | 32 | Contents of register dbgAddr |
| undefFlag | output | 1 | One-cycle pulse: the strobed word matched neither form |
| unpredFlag | output | 1 | One-cycle pulse: the strobed word named register 13 or 15 |

## Verification
If a constant field is misrouted, the wrong value appears on the debug port one edge after the strobe. Sweeping a single set bit through the constant maps each of the sixteen bit positions to its own field. A mistake in the read-modify-write shows up as an upper half that is not cleared after a low-half move, or a lower half that changed after a top-half move. A faulty pattern match shows up as a missing flag pulse, or as a register that changed when it should not have. The bench catches both by flipping each fixed bit of a valid word and then reading back every register.

// File: rtl/wmovPkg.sv
package wmovPkg;
  localparam int IMM_W = 16;
  localparam int IDX_W = 4;

  // Strobes passed from control to datapath
  typedef struct packed {
    logic             wrEn;     // commit a write this edge
    logic             keepLow;  // top-half form: preserve bits below IMM_W
    logic [IDX_W-1:0] rd;       // destination index
    logic [IMM_W-1:0] imm;      // reassembled constant
  } wmovStrb_t;
endpackage

// File: rtl/wmovDecode.sv
module wmovDecode
  import wmovPkg::*;
#(
  parameter int          WORD_W = 32,
  parameter logic [3:0]  SP_IDX = 4'd13,
  parameter logic [3:0]  PC_IDX = 4'd15
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              instrValid,
  input  logic [WORD_W-1:0] instrWord,
  output wmovStrb_t         ctrlStrb,
  output logic              undefFlag,
  output logic              unpredFlag
);
  localparam int HW = WORD_W / 2;

  logic [HW-1:0] hwHi;
  logic [HW-1:0] hwLo;
  logic          formMatch;
  logic          badDest;
  logic [IDX_W-1:0] rdIdx;

  assign hwHi = instrWord[WORD_W-1:HW];
  assign hwLo = instrWord[HW-1:0];

  // Fixed opcode bits of both halfwords
  assign formMatch = (hwHi[15:11] == 5'b11110) && (hwHi[9:8] == 2'b10) &&
                     (hwHi[6:4] == 3'b100) && !hwLo[15];
  assign rdIdx     = hwLo[11:8];
  assign badDest   = (rdIdx == SP_IDX) || (rdIdx == PC_IDX);

  always_comb begin
    ctrlStrb.wrEn    = instrValid && formMatch && !badDest;
    ctrlStrb.keepLow = hwHi[7];
    ctrlStrb.rd      = rdIdx;
    ctrlStrb.imm     = {hwHi[3:0], hwHi[10], hwLo[14:12], hwLo[7:0]};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      undefFlag  <= 1'b0;
      unpredFlag <= 1'b0;
    end else begin
      undefFlag  <= instrValid && !formMatch;
      unpredFlag <= instrValid && formMatch && badDest;
    end
  end
endmodule

// File: rtl/wmovRegFile.sv
module wmovRegFile
  import wmovPkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  wmovStrb_t         ctrlStrb,
  input  logic [IDX_W-1:0]  dbgAddr,
  output logic [DATA_W-1:0] dbgData
);
  localparam int REG_CNT = 1 << IDX_W;
  localparam int HALF_W  = DATA_W / 2;

  logic [DATA_W-1:0] regs [REG_CNT];

  for (genvar g = 0; g < REG_CNT; g++) begin : gEntry
    logic              hit;
    logic [DATA_W-1:0] nextVal;
    assign hit     = ctrlStrb.wrEn && (ctrlStrb.rd == IDX_W'(g));
    assign nextVal = ctrlStrb.keepLow ? {ctrlStrb.imm, regs[g][HALF_W-1:0]}
                                      : {{HALF_W{1'b0}}, ctrlStrb.imm};
    always_ff @(posedge clk) begin
      if (!rstN)    regs[g] <= '0;
      else if (hit) regs[g] <= nextVal;
    end
  end

  assign dbgData = regs[dbgAddr];
endmodule

// File: rtl/wideMoveUnit.sv
module wideMoveUnit
  import wmovPkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              instrValid,
  input  logic [DATA_W-1:0] instrWord,
  input  logic [IDX_W-1:0]  dbgAddr,
  output logic [DATA_W-1:0] dbgData,
  output logic              undefFlag,
  output logic              unpredFlag
);
  wmovStrb_t ctrlStrb;

  wmovDecode #(.WORD_W(DATA_W)) u_dec (
    .clk(clk), .rstN(rstN), .instrValid(instrValid), .instrWord(instrWord),
    .ctrlStrb(ctrlStrb), .undefFlag(undefFlag), .unpredFlag(unpredFlag)
  );

  wmovRegFile #(.DATA_W(DATA_W)) u_rf (
    .clk(clk), .rstN(rstN), .ctrlStrb(ctrlStrb),
    .dbgAddr(dbgAddr), .dbgData(dbgData)
  );
endmodule

// File: rtl/wmovChecker.sv
module wmovChecker
  import wmovPkg::*;
(
  input logic             clk,
  input logic             rstN,
  input logic             instrValid,
  input logic [IDX_W-1:0] dbgAddr,
  input logic [31:0]      dbgData,
  input logic             undefFlag,
  input logic             unpredFlag,
  input wmovStrb_t        ctrlStrb
);
  // R7: an undefined pulse always follows a strobe
  assert_undef_after_strobe_R7: assert property (@(posedge clk) disable iff (!rstN)
    undefFlag |-> $past(instrValid));

  // R8: the two flags never fire together
  assert_flags_exclusive_R8: assert property (@(posedge clk) disable iff (!rstN)
    !(undefFlag && unpredFlag));

  // R9: no strobe, no flag in the next cycle
  assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rstN)
    !instrValid |=> (!undefFlag && !unpredFlag));

  // R9: a write only ever happens with a strobe
  assert_write_needs_strobe_R9: assert property (@(posedge clk) disable iff (!rstN)
    ctrlStrb.wrEn |-> instrValid);

  // R3: top-half write preserves the low half seen on the debug port
  assert_keep_low_R3: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlStrb.wrEn && ctrlStrb.keepLow && dbgAddr == ctrlStrb.rd) |=>
      (!$stable(dbgAddr) || dbgData[15:0] == $past(dbgData[15:0])));

  // R2: low-half write leaves the upper half zero
  assert_clear_high_R2: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlStrb.wrEn && !ctrlStrb.keepLow && dbgAddr == ctrlStrb.rd) |=>
      (!$stable(dbgAddr) || dbgData[31:16] == 16'h0000));
endmodule

bind wideMoveUnit wmovChecker u_chk (
  .clk(clk), .rstN(rstN), .instrValid(instrValid), .dbgAddr(dbgAddr),
  .dbgData(dbgData), .undefFlag(undefFlag), .unpredFlag(unpredFlag),
  .ctrlStrb(ctrlStrb)
);

// File: tb/test_wideMoveUnit.sv
`timescale 1ns/1ps
module test_wideMoveUnit;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        instrValid = 1'b0;
  logic [31:0] instrWord = '0;
  logic [3:0]  dbgAddr = '0;
  logic [31:0] dbgData;
  logic        undefFlag, unpredFlag;

  int checks = 0;
  int errors = 0;
  logic [31:0] model [16];

  always #5 clk = ~clk;

  wideMoveUnit i_wideMoveUnit (
    .clk(clk), .rstN(rstN), .instrValid(instrValid), .instrWord(instrWord),
    .dbgAddr(dbgAddr), .dbgData(dbgData), .undefFlag(undefFlag), .unpredFlag(unpredFlag)
  );

  function automatic logic [31:0] enc(input logic top, input logic [3:0] rd, input logic [15:0] imm);
    return {5'b11110, imm[11], 2'b10, top, 3'b100, imm[15:12],
            1'b0, imm[10:8], rd, imm[7:0]};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Drive one strobed word, check old read (R6), then flags and new value
  task automatic issue(input logic [31:0] w, input logic [3:0] rd, input logic expU,
                       input logic expP, input logic [31:0] expNew, input string req);
    @(negedge clk);
    dbgAddr = rd; instrWord = w; instrValid = 1'b1;
    #1 chk("R6 old value in strobe cycle", dbgData, model[rd]);
    @(negedge clk);
    instrValid = 1'b0;
    #1;
    chk({req, " undef flag"}, {31'b0, undefFlag}, {31'b0, expU});
    chk({req, " unpred flag"}, {31'b0, unpredFlag}, {31'b0, expP});
    chk({req, " value"}, dbgData, expNew);
    model[rd] = expNew;
  endtask

  task automatic dumpAll(input string req);
    for (int r = 0; r < 16; r++) begin
      @(negedge clk);
      dbgAddr = 4'(r);
      #1 chk(req, dbgData, model[r]);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int r = 0; r < 16; r++) model[r] = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    #1 chk("R1 undef after reset", {31'b0, undefFlag}, 32'd0);
    chk("R1 unpred after reset", {31'b0, unpredFlag}, 32'd0);
    dumpAll("R1 reset contents R10");

    // R5 example pair, R2/R3 on the given words
    issue(32'hF6430008, 4'd0, 1'b0, 1'b0, 32'h00003808, "R2 low example");
    issue(32'hF2C40002, 4'd0, 1'b0, 1'b0, 32'h40023808, "R5 pair result R3");

    // Sweep every index with top, low, top
    for (int r = 0; r < 16; r++) begin
      logic [15:0] a, b, c;
      logic bad;
      a = 16'(16'hA5C3 ^ (r * 16'h1111));
      b = 16'(16'h1357 * (r + 1));
      c = ~b;
      bad = (r == 13) || (r == 15);
      if (bad) begin
        issue(enc(1'b1, 4'(r), a), 4'(r), 1'b0, 1'b1, model[r], "R8 top to bad index");
        issue(enc(1'b0, 4'(r), b), 4'(r), 1'b0, 1'b1, model[r], "R8 low to bad index");
      end else begin
        issue(enc(1'b1, 4'(r), a), 4'(r), 1'b0, 1'b0, {a, model[r][15:0]}, "R3 top keeps low");
        issue(enc(1'b0, 4'(r), b), 4'(r), 1'b0, 1'b0, {16'h0, b}, "R2 low clears high");
        issue(enc(1'b1, 4'(r), c), 4'(r), 1'b0, 1'b0, {c, b}, "R3 top over low");
      end
    end
    dumpAll("R10 sweep readback");

    // R4 field mapping: walk one bit through the constant, both forms
    for (int k = 0; k < 16; k++) begin
      issue(enc(1'b0, 4'd5, 16'(1 << k)), 4'd5, 1'b0, 1'b0, 32'(1 << k), "R4 low walking bit");
      issue(enc(1'b1, 4'd5, 16'(1 << k)), 4'd5, 1'b0, 1'b0, {16'(1 << k), 16'(1 << k)}, "R4 top walking bit");
    end

    // R7 undefined: flip each fixed opcode bit of a valid word
    for (int p = 0; p < 32; p++) begin
      if ((p >= 27) || p == 25 || p == 24 || (p >= 20 && p <= 22) || p == 15) begin
        issue(enc(1'b0, 4'd3, 16'hBEEF) ^ (32'd1 << p), 4'd3, 1'b1, 1'b0, model[3], "R7 undefined word");
        @(negedge clk);
        #1 chk("R7 flag single cycle", {31'b0, undefFlag}, 32'd0);
      end
    end
    issue(32'h00000000, 4'd3, 1'b1, 1'b0, model[3], "R7 zero word");
    issue(32'hFFFFFFFF, 4'd3, 1'b1, 1'b0, model[3], "R7 ones word");
    dumpAll("R7 no register changed");

    // R8 single-cycle unpredictable pulse
    issue(enc(1'b0, 4'd13, 16'h7777), 4'd13, 1'b0, 1'b1, model[13], "R8 index 13");
    @(negedge clk);
    #1 chk("R8 flag single cycle", {31'b0, unpredFlag}, 32'd0);

    // R9 unstrobed valid-looking word has no effect
    @(negedge clk);
    dbgAddr = 4'd7; instrWord = enc(1'b0, 4'd7, 16'h1234); instrValid = 1'b0;
    @(negedge clk);
    #1 chk("R9 no write without strobe", dbgData, model[7]);
    chk("R9 flags low without strobe", {30'b0, undefFlag, unpredFlag}, 32'd0);
    dumpAll("R10 final readback");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule